// File: doc/BRIEF.md
# Shader thread dispatch arbiter

This block decides which waiting shader thread goes next to one SIMD array. Vertex, geometry and pixel threads (each a block of 64 data elements) are loaded into three separate per-type queues. Two execution slots can each hold one running thread, so two thread operations are in progress at the same time. A thread keeps its queue entry for its whole life. Its entry is eligible while it waits, held while it runs, and parked while it sleeps on a slow fetch, until a wake-up naming its type and entry index arrives.

Every eligible entry gets a score: a per-type weight taken from a configuration input, plus a saturating age counter. The age grows in each cycle the entry waits without a grant. The highest score wins. Equal scores go to pixel first, then geometry, then vertex, and then to the lower entry index. If both slots are busy and a waiting thread's type weight is strictly above that of a running thread, the block asks the execution side to save that running thread. When the save is acknowledged, the thread goes back to its queue as resumable and the freed slot is granted again. A grant of a resumable thread is flagged so that the slot restores its state.

Top module: `thread_dispatch_arb`

## Requirements
- R1: After a synchronous active-low reset, no grant and no save request are raised, and every queue reports space (`enq_ready` all ones).
- R2: Each type has a queue of QDEPTH entries. `enq_ready[t]` is low exactly when all entries of type t are in use (waiting, running, saving or asleep). An enqueue while the queue is full is dropped and its thread is never granted. Type encoding: vertex=0, geometry=1, pixel=2. In `enq_valid`/`enq_id`, type t sits at bit t and at field t.
- R3: An eligible entry's score is its type weight (`cfg_weight` field t, WT_W bits, vertex lowest) plus its age. The highest score is granted. Equal scores prefer pixel, then geometry, then vertex, then the lower entry index.
- R4: If both slots are idle, slot 0 receives the best candidate and slot 1 the second best. If only one slot is idle, it receives the best. The same entry is never granted to both slots in one cycle.
- R5: An entry's age rises by one in each cycle it is eligible and not granted, and it saturates at 2^AGE_W-1. It clears on grant, on wake-up and on return after a save.
- R6: `slot_done[s]` on a running slot frees both the slot and the thread's entry, and it takes precedence over `slot_sleep[s]` in the same cycle. Done and sleep have no effect on a slot that is not running.
- R7: `slot_sleep[s]` sends the running thread back to its entry, which is not eligible. A wake (`wake_type`, `wake_idx`) makes a sleeping entry eligible. A wake naming an entry that is not asleep has no effect.
- R8: If both slots are running, the best eligible candidate's type weight is strictly greater than a running thread's weight, and no done or sleep arrives on that slot, then the next cycle raises `save_req` on the slot with the lower running weight (slot 0 on a tie), with that thread's id, type and index.
- R9: `save_req[s]` stays high, with stable id, until `save_ack[s]`. No grant goes to that slot meanwhile. After the ack, the slot is idle and the displaced thread is eligible again.
- R10: `gnt_resume[s]` is high when the granted thread earlier left a slot by sleeping or by pre-emption. It is low for a freshly enqueued thread.
- R11: Grant outputs (`gnt_valid`, `gnt_type`, `gnt_idx`, `gnt_id`, `gnt_resume`) depend on registered state and on `cfg_weight` only. The slot starts running on the clock edge that ends the cycle in which the grant is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_weight | input | 3*WT_W | Per-type priority weight, vertex in the low field |
| enq_valid | input | 3 | Enqueue strobe per type |
| enq_id | input | 3*ID_W | Thread id per type |
| enq_ready | output | 3 | Queue of that type has a free entry |
| wake_valid | input | 1 | Data-return wake-up strobe |
| wake_type | input | 2 | Type of the entry to wake |
| wake_idx | input | IDX_W | Entry index to wake |
| slot_done | input | 2 | Running thread of slot s has finished |
| slot_sleep | input | 2 | Running thread of slot s waits on a slow resource |
| gnt_valid | output | 2 | Grant to slot s this cycle |
| gnt_type | output | 4 | Type of granted thread, 2 bits per slot |
| gnt_idx | output | 2*IDX_W | Entry index of granted thread |
| gnt_id | output | 2*ID_W | Id of granted thread |
| gnt_resume | output | 2 | Granted thread needs its saved state restored |
| save_req | output | 2 | Slot s must save its thread for pre-emption |
| save_id | output | 2*ID_W | Id of thread being saved |
| save_type | output | 4 | Type of thread being saved |
| save_idx | output | 2*IDX_W | Entry index of thread being saved |
| save_ack | input | 2 | Save of slot s has completed |

## Verification
The bench builds the block with four entries per queue, a 2-bit age and 3-bit weights. The small queue makes a full queue and a dropped enqueue reachable in a few cycles. The 2-bit age saturates after three waiting cycles, so a thread that has waited five cycles beats a newer pixel thread only if its age has not wrapped. The 3-bit weights allow one type to be configured strictly above the others. That makes pre-emption, the held save handshake and the resumed grant reachable in one short sequence.

// File: rtl/tda_pkg.sv
// Shared types for the shader thread dispatch arbiter.
// Assumes three thread types and two execution slots per SIMD.
package tda_pkg;
    localparam int NTYPE = 3;
    localparam int NSLOT = 2;
    localparam int TY_W  = 2;

    // Type codes; their numeric order is also the tie-break order (higher wins).
    localparam logic [TY_W-1:0] TY_VERTEX   = 2'd0;
    localparam logic [TY_W-1:0] TY_GEOMETRY = 2'd1;
    localparam logic [TY_W-1:0] TY_PIXEL    = 2'd2;

    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_READY = 2'd1,
        ENT_RUN   = 2'd2,
        ENT_SLEEP = 2'd3
    } ent_state_e;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_RUN  = 2'd1,
        SL_SAVE = 2'd2
    } slot_state_e;
endpackage

// File: rtl/tda_queue.sv
// Per-type thread queue.
// Holds QDEPTH thread entries. Each entry stays resident from enqueue until its
// thread completes, and carries a state, an id, a saturating age and a resumable flag.
// Assumes the event masks from the top are mutually exclusive per entry
// and only target entries in the matching state.
module tda_queue
    import tda_pkg::*;
#(
    parameter int QDEPTH = 16,
    parameter int ID_W   = 8,
    parameter int AGE_W  = 4,
    localparam int IDX_W = $clog2(QDEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enq_valid,
    input  logic [ID_W-1:0]              enq_id,
    input  logic [QDEPTH-1:0]            grant_mask,
    input  logic [QDEPTH-1:0]            free_mask,
    input  logic [QDEPTH-1:0]            sleep_mask,
    input  logic [QDEPTH-1:0]            ret_mask,
    input  logic                         wake_valid,
    input  logic [IDX_W-1:0]             wake_idx,
    output logic                         enq_ready,
    output logic [QDEPTH-1:0]            elig_o,
    output logic [QDEPTH-1:0][AGE_W-1:0] age_o,
    output logic [QDEPTH-1:0][ID_W-1:0]  id_o,
    output logic [QDEPTH-1:0]            resum_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    ent_state_e              st  [QDEPTH];
    logic [AGE_W-1:0]        age [QDEPTH];
    logic [ID_W-1:0]         tid [QDEPTH];
    logic [QDEPTH-1:0]       resum;
    logic                    enq_hit;
    logic [IDX_W-1:0]        enq_sel;

    // Find the lowest-numbered free entry for an incoming thread.
    always_comb begin
        enq_hit = 1'b0;
        enq_sel = '0;
        for (int i = QDEPTH-1; i >= 0; i--) begin
            if (st[i] == ENT_FREE) begin
                enq_hit = 1'b1;
                enq_sel = IDX_W'(i);
            end
        end
    end

    assign enq_ready = enq_hit;

    // Expose per-entry view to the picker.
    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            elig_o[i] = (st[i] == ENT_READY);
            age_o[i]  = age[i];
            id_o[i]   = tid[i];
        end
        resum_o = resum;
    end

    // Entry state, age and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QDEPTH; i++) begin
                st[i]  <= ENT_FREE;
                age[i] <= '0;
                tid[i] <= '0;
            end
            resum <= '0;
        end else begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (enq_valid && enq_hit && enq_sel == IDX_W'(i)) begin
                    st[i]    <= ENT_READY;
                    tid[i]   <= enq_id;
                    age[i]   <= '0;
                    resum[i] <= 1'b0;
                end else if (free_mask[i]) begin
                    st[i]    <= ENT_FREE;
                end else if (grant_mask[i]) begin
                    st[i]    <= ENT_RUN;
                    age[i]   <= '0;
                    resum[i] <= 1'b0;
                end else if (sleep_mask[i]) begin
                    st[i]    <= ENT_SLEEP;
                    resum[i] <= 1'b1;
                end else if (ret_mask[i]) begin
                    st[i]    <= ENT_READY;
                    age[i]   <= '0;
                    resum[i] <= 1'b1;
                end else if (wake_valid && wake_idx == IDX_W'(i) && st[i] == ENT_SLEEP) begin
                    st[i]    <= ENT_READY;
                    age[i]   <= '0;
                end else if (st[i] == ENT_READY && age[i] != AGE_MAX) begin
                    age[i]   <= age[i] + 1'b1;
                end
            end
        end
    end

    // R2: a full queue with no completion stays full through a dropped enqueue.
    a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_ready && enq_valid && free_mask == '0) |=> !enq_ready);

    for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_age_chk
        // R5: a waiting entry at maximum age does not wrap.
        a_r5_age_sat: assert property (@(posedge clk) disable iff (!rst_n)
            (elig_o[gi] && age_o[gi] == AGE_MAX && !grant_mask[gi]) |=> age_o[gi] == AGE_MAX);
    end
endmodule

// File: rtl/tda_pick.sv
// Maximum-key picker over all candidates of all queues.
// Keys are unique among candidates (they embed type and index),
// so the result does not depend on the scan order.
module tda_pick #(
    parameter int N     = 48,
    parameter int KEY_W = 11,
    localparam int SEL_W = $clog2(N)
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][KEY_W-1:0] key,
    input  logic [N-1:0]            excl,
    output logic                    found,
    output logic [SEL_W-1:0]        sel
);
    logic [KEY_W-1:0] best;

    // Linear scan keeping the largest key among non-excluded candidates.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        best  = '0;
        for (int g = 0; g < N; g++) begin
            if (cand[g] && !excl[g] && (!found || key[g] > best)) begin
                found = 1'b1;
                sel   = SEL_W'(g);
                best  = key[g];
            end
        end
    end
endmodule

// File: rtl/tda_slot.sv
// One execution slot: idle, running a thread, or saving it for pre-emption.
// Done and sleep are honoured only while running, and done wins over sleep.
// A pre-emption request is dropped if done or sleep arrives in the same cycle.
module tda_slot
    import tda_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_en,
    input  logic [TY_W-1:0]   gnt_type,
    input  logic [IDX_W-1:0]  gnt_idx,
    input  logic [ID_W-1:0]   gnt_id,
    input  logic              done,
    input  logic              sleep,
    input  logic              pre_start,
    input  logic              save_ack,
    output slot_state_e       st_o,
    output logic [TY_W-1:0]   cur_type,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [ID_W-1:0]   cur_id,
    output logic              ev_done,
    output logic              ev_sleep,
    output logic              ev_ret
);
    slot_state_e st;

    assign st_o     = st;
    assign ev_done  = (st == SL_RUN) && done;
    assign ev_sleep = (st == SL_RUN) && sleep && !done;
    assign ev_ret   = (st == SL_SAVE) && save_ack;

    // Slot state machine and capture of the running thread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SL_IDLE;
            cur_type <= '0;
            cur_idx  <= '0;
            cur_id   <= '0;
        end else begin
            case (st)
                SL_IDLE: if (gnt_en) begin
                    st       <= SL_RUN;
                    cur_type <= gnt_type;
                    cur_idx  <= gnt_idx;
                    cur_id   <= gnt_id;
                end
                SL_RUN: begin
                    if (done || sleep) st <= SL_IDLE;
                    else if (pre_start) st <= SL_SAVE;
                end
                SL_SAVE: if (save_ack) st <= SL_IDLE;
                default: st <= SL_IDLE;
            endcase
        end
    end

    // R6: completing a running thread leaves the slot idle.
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SL_RUN && done) |=> st == SL_IDLE);
endmodule

// File: rtl/thread_dispatch_arb.sv
// Shader thread dispatch arbiter: three per-type queues, two slots,
// score = weight + age with type tie-break, and weight-based pre-emption
// through a save handshake. Grants are combinational from registered state and cfg_weight.
module thread_dispatch_arb
    import tda_pkg::*;
#(
    parameter int QDEPTH = 16,
    parameter int ID_W   = 8,
    parameter int AGE_W  = 4,
    parameter int WT_W   = 4,
    localparam int IDX_W = $clog2(QDEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3*WT_W-1:0]      cfg_weight,
    input  logic [2:0]             enq_valid,
    input  logic [3*ID_W-1:0]      enq_id,
    output logic [2:0]             enq_ready,
    input  logic                   wake_valid,
    input  logic [1:0]             wake_type,
    input  logic [IDX_W-1:0]       wake_idx,
    input  logic [1:0]             slot_done,
    input  logic [1:0]             slot_sleep,
    output logic [1:0]             gnt_valid,
    output logic [3:0]             gnt_type,
    output logic [2*IDX_W-1:0]     gnt_idx,
    output logic [2*ID_W-1:0]      gnt_id,
    output logic [1:0]             gnt_resume,
    output logic [1:0]             save_req,
    output logic [2*ID_W-1:0]      save_id,
    output logic [3:0]             save_type,
    output logic [2*IDX_W-1:0]     save_idx,
    input  logic [1:0]             save_ack
);
    localparam int SC_W  = ((WT_W > AGE_W) ? WT_W : AGE_W) + 1;
    localparam int KEY_W = SC_W + TY_W + IDX_W;
    localparam int NCAND = NTYPE * QDEPTH;
    localparam int SEL_W = $clog2(NCAND);

    logic [WT_W-1:0]                wt     [NTYPE];
    logic [QDEPTH-1:0]              elig   [NTYPE];
    logic [QDEPTH-1:0][AGE_W-1:0]   qage   [NTYPE];
    logic [QDEPTH-1:0][ID_W-1:0]    qid    [NTYPE];
    logic [QDEPTH-1:0]              qres   [NTYPE];
    logic [QDEPTH-1:0]              gm     [NTYPE];
    logic [QDEPTH-1:0]              fm     [NTYPE];
    logic [QDEPTH-1:0]              sm     [NTYPE];
    logic [QDEPTH-1:0]              rm     [NTYPE];

    logic [NCAND-1:0]               cand;
    logic [NCAND-1:0][KEY_W-1:0]    key;
    logic [NCAND-1:0]               excl1;
    logic                           f0, f1;
    logic [SEL_W-1:0]               sel0, sel1;

    slot_state_e                    sst    [NSLOT];
    logic [TY_W-1:0]                ctype  [NSLOT];
    logic [IDX_W-1:0]               cidx   [NSLOT];
    logic [ID_W-1:0]                cid    [NSLOT];
    logic [NSLOT-1:0]               ev_done, ev_sleep, ev_ret, pre_start, idle;
    logic [SEL_W-1:0]               gsel   [NSLOT];
    logic [TY_W-1:0]                gty    [NSLOT];
    logic [IDX_W-1:0]               gix    [NSLOT];
    logic [ID_W-1:0]                gidv   [NSLOT];
    logic [NSLOT-1:0]               gres;

    logic [TY_W-1:0]                p_type;
    logic [WT_W-1:0]                p_wt, rw0, rw1, rwmin;
    logic                           all_run, tgt;

    // Per-type weight fields.
    for (genvar t = 0; t < NTYPE; t++) begin : g_wt
        assign wt[t] = cfg_weight[t*WT_W +: WT_W];
    end

    // One queue per thread type.
    for (genvar t = 0; t < NTYPE; t++) begin : g_q
        tda_queue #(.QDEPTH(QDEPTH), .ID_W(ID_W), .AGE_W(AGE_W)) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .enq_valid  (enq_valid[t]),
            .enq_id     (enq_id[t*ID_W +: ID_W]),
            .grant_mask (gm[t]),
            .free_mask  (fm[t]),
            .sleep_mask (sm[t]),
            .ret_mask   (rm[t]),
            .wake_valid (wake_valid && wake_type == TY_W'(t)),
            .wake_idx   (wake_idx),
            .enq_ready  (enq_ready[t]),
            .elig_o     (elig[t]),
            .age_o      (qage[t]),
            .id_o       (qid[t]),
            .resum_o    (qres[t])
        );
    end

    // Build candidate keys: {score, type, inverted index}.
    always_comb begin
        for (int t = 0; t < NTYPE; t++) begin
            for (int i = 0; i < QDEPTH; i++) begin
                cand[t*QDEPTH+i] = elig[t][i];
                key[t*QDEPTH+i]  = {SC_W'(wt[t]) + SC_W'(qage[t][i]), TY_W'(t), ~IDX_W'(i)};
            end
        end
    end

    // Exclude the first pick from the second.
    always_comb begin
        excl1 = '0;
        if (f0) excl1[sel0] = 1'b1;
    end

    tda_pick #(.N(NCAND), .KEY_W(KEY_W)) u_pick0 (
        .cand (cand), .key (key), .excl ('0), .found (f0), .sel (sel0)
    );

    tda_pick #(.N(NCAND), .KEY_W(KEY_W)) u_pick1 (
        .cand (cand), .key (key), .excl (excl1), .found (f1), .sel (sel1)
    );

    // Route picks to idle slots: slot 0 first, slot 1 takes the best if slot 0 is busy.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) idle[s] = (sst[s] == SL_IDLE);
        gnt_valid[0] = idle[0] && f0;
        gnt_valid[1] = idle[1] && (idle[0] ? f1 : f0);
        gsel[0] = sel0;
        gsel[1] = idle[0] ? sel1 : sel0;
        for (int s = 0; s < NSLOT; s++) begin
            gty[s]  = TY_W'(int'(gsel[s]) / QDEPTH);
            gix[s]  = IDX_W'(int'(gsel[s]) % QDEPTH);
            gidv[s] = '0;
            gres[s] = 1'b0;
            for (int t = 0; t < NTYPE; t++) begin
                if (gty[s] == TY_W'(t)) begin
                    gidv[s] = qid[t][gix[s]];
                    gres[s] = qres[t][gix[s]];
                end
            end
        end
    end

    // Pre-emption decision against the lower-weight running thread.
    always_comb begin
        p_type = TY_W'(int'(sel0) / QDEPTH);
        p_wt = '0; rw0 = '0; rw1 = '0;
        for (int t = 0; t < NTYPE; t++) begin
            if (p_type == TY_W'(t))   p_wt = wt[t];
            if (ctype[0] == TY_W'(t)) rw0  = wt[t];
            if (ctype[1] == TY_W'(t)) rw1  = wt[t];
        end
        all_run   = (sst[0] == SL_RUN) && (sst[1] == SL_RUN);
        tgt       = (rw1 < rw0);
        rwmin     = tgt ? rw1 : rw0;
        pre_start = '0;
        if (all_run && f0 && p_wt > rwmin) pre_start[tgt] = 1'b1;
    end

    // Translate slot events into per-queue entry masks.
    always_comb begin
        for (int t = 0; t < NTYPE; t++) begin
            gm[t] = '0; fm[t] = '0; sm[t] = '0; rm[t] = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (gnt_valid[s] && gty[s] == TY_W'(t))   gm[t][gix[s]]  = 1'b1;
                if (ev_done[s]   && ctype[s] == TY_W'(t)) fm[t][cidx[s]] = 1'b1;
                if (ev_sleep[s]  && ctype[s] == TY_W'(t)) sm[t][cidx[s]] = 1'b1;
                if (ev_ret[s]    && ctype[s] == TY_W'(t)) rm[t][cidx[s]] = 1'b1;
            end
        end
    end

    // Two execution slots with their output fields.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        tda_slot #(.ID_W(ID_W), .IDX_W(IDX_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .gnt_en    (gnt_valid[s]),
            .gnt_type  (gty[s]),
            .gnt_idx   (gix[s]),
            .gnt_id    (gidv[s]),
            .done      (slot_done[s]),
            .sleep     (slot_sleep[s]),
            .pre_start (pre_start[s]),
            .save_ack  (save_ack[s]),
            .st_o      (sst[s]),
            .cur_type  (ctype[s]),
            .cur_idx   (cidx[s]),
            .cur_id    (cid[s]),
            .ev_done   (ev_done[s]),
            .ev_sleep  (ev_sleep[s]),
            .ev_ret    (ev_ret[s])
        );

        assign gnt_type[s*TY_W +: TY_W]   = gty[s];
        assign gnt_idx[s*IDX_W +: IDX_W]  = gix[s];
        assign gnt_id[s*ID_W +: ID_W]     = gidv[s];
        assign gnt_resume[s]              = gnt_valid[s] && gres[s];
        assign save_req[s]                = (sst[s] == SL_SAVE);
        assign save_id[s*ID_W +: ID_W]    = cid[s];
        assign save_type[s*TY_W +: TY_W]  = ctype[s];
        assign save_idx[s*IDX_W +: IDX_W] = cidx[s];

        // R9: a slot being saved receives no grant.
        a_r9_no_grant_saving: assert property (@(posedge clk) disable iff (!rst_n)
            save_req[s] |-> !gnt_valid[s]);

        // R9: the save request holds with a stable id until acknowledged.
        a_r9_save_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (save_req[s] && !save_ack[s]) |=> (save_req[s] && $stable(save_id[s*ID_W +: ID_W])));

        // R8: a save only starts when both slots were running.
        a_r8_save_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(save_req[s]) |-> $past(all_run));
    end

    // R4: the two grants of one cycle never name the same entry.
    a_r4_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid == 2'b11) |-> (gsel[0] != gsel[1]));
endmodule

// File: tb/thread_dispatch_arb_bench.sv
`timescale 1ns/1ps
module thread_dispatch_arb_bench;
    localparam int QD = 4;
    localparam int IW = 8;
    localparam int AW = 2;
    localparam int WW = 3;
    localparam int XW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [3*WW-1:0] cfg_weight;
    logic [2:0]      enq_valid;
    logic [3*IW-1:0] enq_id;
    logic [2:0]      enq_ready;
    logic            wake_valid;
    logic [1:0]      wake_type;
    logic [XW-1:0]   wake_idx;
    logic [1:0]      slot_done, slot_sleep;
    logic [1:0]      gnt_valid, gnt_resume, save_req, save_ack;
    logic [3:0]      gnt_type, save_type;
    logic [2*XW-1:0] gnt_idx, save_idx;
    logic [2*IW-1:0] gnt_id, save_id;

    int nchk = 0;
    int nbad = 0;
    int ngrant = 0;
    bit saw55 = 1'b0;

    always #5 clk = ~clk;

    thread_dispatch_arb #(.QDEPTH(QD), .ID_W(IW), .AGE_W(AW), .WT_W(WW)) u_thread_dispatch_arb (
        .clk(clk), .rst_n(rst_n), .cfg_weight(cfg_weight),
        .enq_valid(enq_valid), .enq_id(enq_id), .enq_ready(enq_ready),
        .wake_valid(wake_valid), .wake_type(wake_type), .wake_idx(wake_idx),
        .slot_done(slot_done), .slot_sleep(slot_sleep),
        .gnt_valid(gnt_valid), .gnt_type(gnt_type), .gnt_idx(gnt_idx),
        .gnt_id(gnt_id), .gnt_resume(gnt_resume),
        .save_req(save_req), .save_id(save_id), .save_type(save_type),
        .save_idx(save_idx), .save_ack(save_ack)
    );

    // Rows: {enq[2:0], done[1:0], sleep[1:0], exp_gv[1:0], exp_t0[1:0], exp_t1[1:0]}
    localparam logic [12:0] TBL [7] = '{
        13'b111_00_00_00_00_00,
        13'b000_00_00_11_10_01,
        13'b000_01_00_00_00_00,
        13'b000_00_00_01_00_00,
        13'b000_00_10_00_00_00,
        13'b100_00_00_00_00_00,
        13'b000_00_00_10_00_10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Record grants, advance one edge, then clear one-cycle strobes at the falling edge.
    task automatic nxt();
        for (int s = 0; s < 2; s++) begin
            if (gnt_valid[s]) begin
                ngrant++;
                if (gnt_id[s*IW +: IW] == 8'h55) saw55 = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        enq_valid = '0; slot_done = '0; slot_sleep = '0;
        wake_valid = 1'b0; save_ack = '0;
    endtask

    task automatic do_reset(input logic [3*WW-1:0] w);
        cfg_weight = w;
        enq_valid = '0; enq_id = '0; slot_done = '0; slot_sleep = '0;
        wake_valid = 1'b0; wake_type = '0; wake_idx = '0; save_ack = '0;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        ngrant = 0; saw55 = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL R11 watchdog act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset({3'd1, 3'd1, 3'd1});
        check("R1 gnt_valid", 32'(gnt_valid), 0);
        check("R1 save_req", 32'(save_req), 0);
        check("R1 enq_ready", 32'(enq_ready), 32'h7);

        // Table walk: R3 tie order, R4 two grants, R6 done, R7 sleep, R11 timing
        for (int r = 0; r < 7; r++) begin
            check("R4 R11 table gnt_valid", 32'(gnt_valid), 32'(TBL[r][5:4]));
            if (TBL[r][4]) check("R3 table slot0 type", 32'(gnt_type[1:0]), 32'(TBL[r][3:2]));
            if (TBL[r][5]) check("R3 table slot1 type", 32'(gnt_type[3:2]), 32'(TBL[r][1:0]));
            enq_valid  = TBL[r][12:10];
            enq_id     = {8'(r*4+2), 8'(r*4+1), 8'(r*4)};
            slot_done  = TBL[r][9:8];
            slot_sleep = TBL[r][7:6];
            nxt();
        end

        // R3 weight dominates pixel tie preference
        do_reset({3'd1, 3'd1, 3'd3});
        enq_valid = 3'b101; enq_id = {8'h31, 8'h00, 8'h30};
        nxt();
        check("R3 weight slot0 type", 32'(gnt_type[1:0]), 0);
        check("R3 weight slot1 type", 32'(gnt_type[3:2]), 2);

        // R7 sleep/wake, R4 single candidate, R10 resume flag, R6 done beats sleep
        do_reset({3'd1, 3'd1, 3'd1});
        enq_valid = 3'b001; enq_id = {16'h0, 8'h09};
        nxt();
        check("R4 single candidate slot0 only", 32'(gnt_valid), 1);
        check("R10 fresh not resume", 32'(gnt_resume), 0);
        nxt();
        slot_sleep = 2'b01;
        nxt();
        check("R7 sleeping not granted", 32'(gnt_valid), 0);
        wake_valid = 1'b1; wake_type = 2'd0; wake_idx = 2'd1;
        nxt();
        check("R7 wake to other entry ignored", 32'(gnt_valid), 0);
        wake_valid = 1'b1; wake_type = 2'd0; wake_idx = 2'd0;
        nxt();
        check("R7 woken granted", 32'(gnt_valid), 1);
        check("R7 woken id", 32'(gnt_id[7:0]), 32'h09);
        check("R10 woken resume", 32'(gnt_resume), 1);
        nxt();
        slot_done = 2'b01; slot_sleep = 2'b01;
        nxt();
        wake_valid = 1'b1; wake_type = 2'd0; wake_idx = 2'd0;
        nxt();
        check("R6 done beats sleep, no regrant", 32'(gnt_valid), 0);

        // R2 full queue drops enqueue; R6 done on idle slot ignored
        do_reset({3'd1, 3'd1, 3'd1});
        for (int k = 1; k <= 4; k++) begin
            check("R2 ready before fill", 32'(enq_ready[0]), 1);
            enq_valid = 3'b001; enq_id = {16'h0, 8'(k)};
            nxt();
        end
        check("R2 full", 32'(enq_ready[0]), 0);
        enq_valid = 3'b001; enq_id = {16'h0, 8'h55};
        nxt();
        check("R2 still full", 32'(enq_ready[0]), 0);
        for (int k = 0; k < 10; k++) begin
            slot_done = 2'b11;
            nxt();
        end
        check("R2 grant count", 32'(ngrant), 4);
        check("R2 dropped thread never granted", 32'(saw55), 0);

        // R5 aging with saturation beats newer pixel thread
        do_reset({3'd1, 3'd1, 3'd1});
        enq_valid = 3'b011; enq_id = {8'h00, 8'h10, 8'h20};
        nxt();
        check("R3 tie geometry over vertex", 32'(gnt_type), 32'b0001);
        nxt();
        enq_valid = 3'b001; enq_id = {16'h0, 8'h21};
        nxt();
        nxt();
        nxt();
        enq_valid = 3'b100; enq_id = {8'h30, 16'h0};
        nxt();
        nxt();
        slot_done = 2'b01;
        nxt();
        check("R5 aged vertex granted", 32'(gnt_valid), 1);
        check("R5 aged vertex id", 32'(gnt_id[7:0]), 32'h21);

        // R8 pre-emption, R9 save handshake, R10 resumed grant
        do_reset({3'd3, 3'd1, 3'd1});
        enq_valid = 3'b011; enq_id = {8'h00, 8'h40, 8'h41};
        nxt();
        nxt();
        enq_valid = 3'b100; enq_id = {8'h42, 16'h0};
        nxt();
        check("R8 no save yet", 32'(save_req), 0);
        nxt();
        check("R8 save on slot0", 32'(save_req), 1);
        check("R8 save id", 32'(save_id[7:0]), 32'h40);
        check("R8 save type", 32'(save_type[1:0]), 1);
        nxt();
        check("R9 save held", 32'(save_req), 1);
        check("R9 no grant while saving", 32'(gnt_valid), 0);
        save_ack = 2'b01;
        nxt();
        check("R9 released", 32'(save_req), 0);
        check("R9 slot regranted", 32'(gnt_valid), 1);
        check("R9 new thread id", 32'(gnt_id[7:0]), 32'h42);
        check("R10 new thread not resume", 32'(gnt_resume), 0);
        nxt();
        check("R8 equal weight no save", 32'(save_req), 0);
        slot_done = 2'b10;
        nxt();
        check("R10 displaced regranted", 32'(gnt_valid), 2);
        check("R10 displaced id", 32'(gnt_id[15:8]), 32'h40);
        check("R10 resume flag", 32'(gnt_resume), 2);

        summary();
        $finish;
    end
endmodule